// File: doc/BRIEF.md
# Byte-Serial Register-Write Command Decoder

This block sits at the end of a narrow command bus. Each register write arrives as a burst of bytes on an 8-bit lane. A strobe flags the first byte of the burst, and the following bytes come on consecutive clock cycles. The block gathers a 16-bit command address and a 32-bit payload from the burst. It then checks the address against two programmable base/mask windows and, for each window that matches, raises that window's write strobe for exactly one cycle. The low address bits and the payload are presented alongside the strobe.

A register bank behind the block uses the local address to select a location within the window whose strobe fired. Bytes that do not belong to a command are ignored. A strobe that arrives while a command is still being collected abandons the partial command and starts a new one. Everything runs on one clock with a synchronous, active-high reset.

Top module: `bytecmd_decoder`

## Requirements
- R1: A command is six bytes, one per cycle. Byte 0 (flagged by the strobe) is address bits 7:0 and byte 1 is address bits 15:8. Bytes 2 to 5 are payload bits 7:0, 15:8, 23:16 and 31:24, and `wr_data` presents the payload.
- R2: `bus_first` is high only with byte 0. The five bytes sampled on the next five clock edges complete the command, and these bytes are taken with `bus_first` low.
- R3: `wr_addr` equals command address bits 3:0.
- R4: Window k matches when (address AND mask_k) equals (base_k AND mask_k), and a match drives `wr_en[k]`. The defaults are window 0 with base 0x0730 and mask 0xFFF8 (8 locations), and window 1 with base 0x0738 and mask 0xFFFE (2 locations).
- R5: `wr_en` is high for exactly one cycle: the cycle that follows the clock edge that samples byte 5. `wr_addr` and `wr_data` take the command's values in that same cycle.
- R6: A strobe that arrives before byte 5 has been taken discards the partial command (no write pulse for it), and its byte becomes byte 0 of a new command.
- R7: Bytes presented with `bus_first` low while no command is in progress cause no pulse and leave `wr_addr` and `wr_data` unchanged.
- R8: A synchronous reset drives `wr_en`, `wr_addr` and `wr_data` to zero and drops any command in progress. Bytes that follow the reset without a strobe produce no pulse.
- R9: When neither window matches, `wr_en` stays 0. `wr_addr` and `wr_data` still take the completed command's values.
- R10: A strobe may arrive in the cycle right after byte 5. Back-to-back commands each complete and each pulse once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_byte | input | 8 | Command byte lane |
| bus_first | input | 1 | High with the first byte of a command |
| wr_addr | output | LOCAL_W (4) | Low address bits of the last completed command |
| wr_data | output | 32 | Payload of the last completed command |
| wr_en | output | 2 | One-cycle write strobe per window |

## Verification
Two functions can fall in the same cycle. The first case is a completion pulse and the strobe of the next command: back-to-back commands put the pulse in the very cycle that byte 0 of the following command is sampled. The second case is a restart and the final byte: a strobe is placed exactly where byte 5 would have been. In both cases a cycle-accurate behavioural model, built from a byte queue, predicts `wr_en`, `wr_addr` and `wr_data` every cycle. A mismatch in either direction is counted, whether it is a missing pulse, a pulse for the abandoned command, or stale data.

// File: rtl/bytecmd_pkg.sv
package bytecmd_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 2;
    localparam int DATA_BYTES = 4;
    localparam int CMD_BYTES  = ADDR_BYTES + DATA_BYTES;
    localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
    localparam int DATA_W     = DATA_BYTES * BYTE_W;
    localparam int SLOT_W     = $clog2(CMD_BYTES + 1);
    localparam int NUM_WIN    = 2;

    typedef logic [BYTE_W-1:0]           byte_t;
    typedef logic [SLOT_W-1:0]           slot_t;
    typedef logic [ADDR_W-1:0]           addr_t;
    typedef logic [CMD_BYTES*BYTE_W-1:0] cmd_flat_t;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_COLLECT = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_word_t;

    // Byte k of the burst lives at flat[k*BYTE_W +: BYTE_W].
    function automatic cmd_word_t unpack_cmd(input cmd_flat_t flat);
        cmd_word_t c;
        c = '0;
        for (int k = 0; k < ADDR_BYTES; k++)
            c.addr[k*BYTE_W +: BYTE_W] = flat[k*BYTE_W +: BYTE_W];
        for (int k = 0; k < DATA_BYTES; k++)
            c.data[k*BYTE_W +: BYTE_W] = flat[(ADDR_BYTES+k)*BYTE_W +: BYTE_W];
        return c;
    endfunction

    function automatic logic window_hit(input addr_t a, input addr_t base, input addr_t mask);
        return ((a & mask) == (base & mask));
    endfunction

endpackage

// File: rtl/bytecmd_collect.sv
module bytecmd_collect
    import bytecmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  byte_t     bus_byte,
    input  logic      bus_first,
    output cmd_word_t cmd,
    output logic      done
);

    localparam slot_t LAST_SLOT = slot_t'(CMD_BYTES - 1);

    rx_state_e state;
    slot_t     slot;
    cmd_flat_t acc;
    cmd_flat_t acc_next;

    always_comb begin
        acc_next = acc;
        acc_next[int'(slot)*BYTE_W +: BYTE_W] = bus_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            slot  <= '0;
            acc   <= '0;
            cmd   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (bus_first) begin
                acc   <= cmd_flat_t'(bus_byte);
                slot  <= slot_t'(1);
                state <= ST_COLLECT;
            end else if (state == ST_COLLECT) begin
                if (slot == LAST_SLOT) begin
                    cmd   <= unpack_cmd(acc_next);
                    done  <= 1'b1;
                    slot  <= '0;
                    state <= ST_IDLE;
                end else begin
                    acc  <= acc_next;
                    slot <= slot + slot_t'(1);
                end
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R5
    AST_STROBE_RESTART: assert property (@(posedge clk) disable iff (rst)
        bus_first |=> (state == ST_COLLECT && slot == slot_t'(1)));  // R6
    AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !bus_first) |=> ($stable(cmd) && !done));  // R7
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(slot) == LAST_SLOT && !$past(bus_first)));  // R2

endmodule

// File: rtl/bytecmd_window.sv
module bytecmd_window
    import bytecmd_pkg::*;
#(
    parameter addr_t BASE = '0,
    parameter addr_t MASK = '0
) (
    input  addr_t addr,
    output logic  hit
);

    assign hit = window_hit(addr, BASE, MASK);

endmodule

// File: rtl/bytecmd_decoder.sv
module bytecmd_decoder
    import bytecmd_pkg::*;
#(
    parameter int          LOCAL_W   = 4,
    parameter logic [15:0] WIN0_BASE = 16'h0730,
    parameter logic [15:0] WIN0_MASK = 16'hFFF8,
    parameter logic [15:0] WIN1_BASE = 16'h0738,
    parameter logic [15:0] WIN1_MASK = 16'hFFFE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [BYTE_W-1:0]   bus_byte,
    input  logic                bus_first,
    output logic [LOCAL_W-1:0]  wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic [NUM_WIN-1:0]  wr_en
);

    cmd_word_t          cmd;
    logic               done;
    logic [NUM_WIN-1:0] hit;

    bytecmd_collect u_collect (
        .clk       (clk),
        .rst       (rst),
        .bus_byte  (bus_byte),
        .bus_first (bus_first),
        .cmd       (cmd),
        .done      (done)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam addr_t W_BASE = (g == 0) ? addr_t'(WIN0_BASE) : addr_t'(WIN1_BASE);
        localparam addr_t W_MASK = (g == 0) ? addr_t'(WIN0_MASK) : addr_t'(WIN1_MASK);
        bytecmd_window #(
            .BASE (W_BASE),
            .MASK (W_MASK)
        ) u_win (
            .addr (cmd.addr),
            .hit  (hit[g])
        );
    end

    assign wr_en   = done ? hit : '0;
    assign wr_addr = cmd.addr[LOCAL_W-1:0];
    assign wr_data = cmd.data;

    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (|wr_en) |=> (wr_en == '0));  // R5
    AST_WE_AFTER_BYTES: assert property (@(posedge clk) disable iff (rst)
        (|wr_en) |-> !$past(bus_first));  // R2

endmodule

// File: tb/bytecmd_decoder_tb.sv
`timescale 1ns/1ps
module bytecmd_decoder_tb;

    localparam logic [15:0] B0 = 16'h0730, M0 = 16'hFFF8;
    localparam logic [15:0] B1 = 16'h0738, M1 = 16'hFFFE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_first = 1'b0;
    logic [7:0]  bus_byte = 8'h00;
    logic [3:0]  wr_addr;
    logic [31:0] wr_data;
    logic [1:0]  wr_en;

    int checks = 0;
    int failures = 0;

    int          m_cnt = 0;
    logic [7:0]  m_q[$];
    logic [3:0]  e_addr = '0;
    logic [31:0] e_data = '0;
    logic [1:0]  e_en = '0;

    always #2 clk = ~clk;

    bytecmd_decoder u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_byte  (bus_byte),
        .bus_first (bus_first),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_en     (wr_en)
    );

    task automatic check(input string tag);
        checks++;
        if ({wr_en, wr_addr, wr_data} !== {e_en, e_addr, e_data}) begin
            failures++;
            $display("FAIL %s en=%b addr=%h data=%h expected en=%b addr=%h data=%h",
                     tag, wr_en, wr_addr, wr_data, e_en, e_addr, e_data);
        end
    endtask

    // Predicts the outputs after the coming clock edge.
    task automatic model(input logic r, input logic f, input logic [7:0] b);
        logic [15:0] a;
        if (r) begin
            m_cnt = 0; m_q.delete();
            e_en = '0; e_addr = '0; e_data = '0;
        end else begin
            e_en = '0;
            if (f) begin
                m_q.delete(); m_q.push_back(b); m_cnt = 1;
            end else if (m_cnt > 0) begin
                m_q.push_back(b); m_cnt++;
                if (m_cnt == 6) begin
                    a      = {m_q[1], m_q[0]};
                    e_addr = a[3:0];
                    e_data = {m_q[5], m_q[4], m_q[3], m_q[2]};
                    e_en[0] = ((a & M0) == (B0 & M0));
                    e_en[1] = ((a & M1) == (B1 & M1));
                    m_cnt  = 0;
                end
            end
        end
    endtask

    task automatic drive(input logic r, input logic f, input logic [7:0] b, input string tag);
        @(negedge clk);
        check(tag);
        model(r, f, b);
        rst = r; bus_first = f; bus_byte = b;
    endtask

    task automatic send(input logic [15:0] a, input logic [31:0] d, input string tag);
        drive(1'b0, 1'b1, a[7:0], tag);
        drive(1'b0, 1'b0, a[15:8], tag);
        for (int k = 0; k < 4; k++) drive(1'b0, 1'b0, d[k*8 +: 8], tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) drive(1'b0, 1'b0, 8'h5A ^ 8'(k * 37), tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) drive(1'b1, 1'b0, 8'h00, "R8 reset state");
        idle(2, "R8 post-reset quiet");
        send(16'h0730, 32'h11223344, "R1 R4 window0 base");
        idle(2, "R5 pulse ends");
        send(16'h0737, 32'hA5A5F00F, "R3 window0 top");
        idle(1, "R5");
        send(16'h0738, 32'hDEADBEEF, "R4 window1 base");
        idle(1, "R5");
        send(16'h0739, 32'h01020304, "R3 window1 top");
        idle(1, "R5");
        send(16'h073A, 32'hCAFEBABE, "R9 miss above window1");
        idle(1, "R9");
        send(16'h072F, 32'h0BADF00D, "R9 miss below window0");
        idle(1, "R9");
        send(16'h1730, 32'h12345678, "R9 miss high byte");
        idle(1, "R9");
        idle(8, "R7 stray bytes while idle");
        drive(1'b0, 1'b0, 8'h30, "R7");
        drive(1'b0, 1'b0, 8'h07, "R7");
        idle(6, "R7 no pulse");
        drive(1'b0, 1'b1, 8'h31, "R6 partial");
        drive(1'b0, 1'b0, 8'h07, "R6 partial");
        drive(1'b0, 1'b0, 8'hEE, "R6 partial");
        send(16'h0739, 32'h55667788, "R6 restart early");
        idle(1, "R6");
        drive(1'b0, 1'b1, 8'h32, "R6 partial");
        for (int k = 0; k < 4; k++) drive(1'b0, 1'b0, 8'h07 + 8'(k), "R6 partial");
        send(16'h0734, 32'h99AABBCC, "R6 strobe on last slot");
        idle(2, "R6");
        send(16'h0731, 32'h10203040, "R10 back to back");
        send(16'h0738, 32'h50607080, "R10 back to back");
        send(16'h0800, 32'h90A0B0C0, "R10 back to back miss");
        send(16'h0736, 32'hD0E0F000, "R2 R10 back to back");
        idle(2, "R10");
        drive(1'b0, 1'b1, 8'h33, "R8 mid-command");
        drive(1'b0, 1'b0, 8'h07, "R8 mid-command");
        drive(1'b0, 1'b0, 8'h01, "R8 mid-command");
        drive(1'b1, 1'b0, 8'h02, "R8 reset mid-command");
        for (int k = 0; k < 4; k++) drive(1'b0, 1'b0, 8'h03, "R8 tail ignored");
        idle(3, "R8");
        send(16'h0735, 32'hFEEDFACE, "R1 R3 after reset");
        idle(3, "R5 final");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule